// File: doc/BRIEF.md
# Two-level interrupt mask controller

This block collects level-sensitive interrupt requests from a set of devices and delivers them to up to four CPUs, one interrupt line per CPU. A request reaches a CPU only after passing two independent gates. The first is a global enable kept once per source. The second is a mask kept for every source inside each CPU. Sources numbered above a fixed boundary are shared sources. These also need their routing register to select the CPU. Sources at or below the boundary are per-CPU sources and are not affected by routing. Software normally masks per-CPU sources through the per-CPU mask and shared sources through the global enable.

Software programs the gates over a simple register bus with one-cycle writes and combinational reads. Gates are set and cleared by writing a source number to a dedicated set or clear register, not by writing a bitmap, so no read-modify-write is needed. A CPU-id sideband on the bus selects whose mask is written and whose acknowledge value is read. Reading the acknowledge register gives the lowest-numbered source that is currently eligible for that CPU, or an idle code when none is. A read-only control register reports the number of implemented sources.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset every global enable is clear, every per-CPU mask is set and every routing register reads zero, so every CPU line is low and every acknowledge read returns 1023.
- R2: A write to offset 0x30 enables the source whose number is in write-data bits [9:0]. A write to offset 0x34 disables it. The change is visible from the cycle after the write.
- R3: A write of a source number to offset 0x48 masks that source only for the CPU given on the CPU-id sideband. A write to offset 0x4C unmasks it only for that CPU.
- R4: The routing register of source s sits at 0x100 + 4*s and holds write-data bits [3:0], one bit per CPU (bit c selects CPU c). A read returns the stored bits, and the higher bits read as zero.
- R5: A shared source (number 29 or above) reaches CPU c only when bit c of its routing register is set. A per-CPU source (0 to 28) ignores its routing register.
- R6: CPU line c is high exactly when at least one source is eligible for CPU c. A source is eligible when its input is high, it is globally enabled, it is unmasked for c and, for a shared source, it is routed to c. The line follows the source inputs in the same cycle.
- R7: A read of offset 0x44 returns, in bits [9:0], the lowest-numbered source eligible for the CPU on the sideband, or 1023 when none is eligible. Bits [31:10] are zero. The read changes no state.
- R8: A read of offset 0x00 returns the implemented source count in bits [11:2], with all other bits zero.
- R9: Set and clear writes whose bits [9:0] name an unimplemented source change nothing. Bits above [9:0] of such writes are ignored. Routing writes and reads beyond the last source have no effect and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRCS | Level interrupt requests, bit s for source s |
| bus_en_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_cpu_i | input | CPU_W | Id of the accessing CPU |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | NUM_CPUS | Interrupt line per CPU |

## Verification
A single shared source is taken through routing, unmasking and enabling in turn. This shows that each gate is needed on its own and that toggling the enable has the intended effect. A per-CPU source unmasked on one CPU only separates the mask of the accessing CPU from the masks of the others, and its empty routing register shows that routing is bypassed below the boundary. Several sources are then made eligible for one CPU together, then masked and dropped one by one, which shows the lowest-number choice and the idle code. Writes naming numbers past the last source, and data with set upper bits, separate a correct index decode from an aliasing or width-truncating one.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int IDX_W  = 10;
  localparam int DATA_W = 32;
  localparam logic [IDX_W-1:0] IDX_NONE = '1;

  localparam int OFS_CTRL    = 'h000;
  localparam int OFS_EN_SET  = 'h030;
  localparam int OFS_EN_CLR  = 'h034;
  localparam int OFS_ACK     = 'h044;
  localparam int OFS_MSK_SET = 'h048;
  localparam int OFS_MSK_CLR = 'h04C;
  localparam int OFS_ROUTE   = 'h100;

  typedef enum logic [2:0] {
    OP_NONE, OP_EN_SET, OP_EN_CLR, OP_MSK_SET, OP_MSK_CLR, OP_ROUTE
  } wr_op_e;
endpackage

// File: rtl/irq_bank_regs.sv
module irq_bank_regs
  import irq_mask_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int NUM_SRCS = 64,
  parameter int CPU_W    = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  wr_op_e                             op_i,
  input  logic [IDX_W-1:0]                   idx_i,
  input  logic [CPU_W-1:0]                   cpu_i,
  input  logic [NUM_CPUS-1:0]                route_d_i,
  output logic [NUM_SRCS-1:0]                en_o,
  output logic [NUM_CPUS-1:0][NUM_SRCS-1:0]  msk_o,
  output logic [NUM_SRCS-1:0][NUM_CPUS-1:0]  route_o
);
  for (genvar s = 0; s < NUM_SRCS; s++) begin : g_src
    logic hit;
    assign hit = (idx_i == IDX_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          en_o[s] <= 1'b0;
      else if (hit && op_i == OP_EN_SET)    en_o[s] <= 1'b1;
      else if (hit && op_i == OP_EN_CLR)    en_o[s] <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          route_o[s] <= '0;
      else if (hit && op_i == OP_ROUTE)     route_o[s] <= route_d_i;
    end

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      logic mine;
      assign mine = hit && (cpu_i == CPU_W'(c));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         msk_o[c][s] <= 1'b1;
        else if (mine && op_i == OP_MSK_SET) msk_o[c][s] <= 1'b1;
        else if (mine && op_i == OP_MSK_CLR) msk_o[c][s] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_cpu_sel.sv
module irq_cpu_sel
  import irq_mask_pkg::*;
#(
  parameter int NUM_SRCS  = 64,
  parameter int PCPU_LAST = 28
) (
  input  logic [NUM_SRCS-1:0] src_i,
  input  logic [NUM_SRCS-1:0] en_i,
  input  logic [NUM_SRCS-1:0] msk_i,
  input  logic [NUM_SRCS-1:0] route_i,
  output logic                irq_o,
  output logic [IDX_W-1:0]    ack_o
);
  logic [NUM_SRCS-1:0] elig;

  for (genvar s = 0; s < NUM_SRCS; s++) begin : g_elig
    if (s <= PCPU_LAST) begin : g_pcpu
      assign elig[s] = src_i[s] & en_i[s] & ~msk_i[s];
    end else begin : g_shared
      assign elig[s] = src_i[s] & en_i[s] & ~msk_i[s] & route_i[s];
    end
  end

  assign irq_o = |elig;

  // lowest number wins
  always_comb begin
    ack_o = IDX_NONE;
    for (int s = NUM_SRCS - 1; s >= 0; s--)
      if (elig[s]) ack_o = IDX_W'(s);
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_SRCS  = 64,
  parameter int PCPU_LAST = 28,
  parameter int ADDR_W    = 12,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRCS-1:0] src_i,
  input  logic                bus_en_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  input  logic [CPU_W-1:0]    bus_cpu_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic [NUM_CPUS-1:0] irq_o
);
  wr_op_e                            op;
  logic [IDX_W-1:0]                  idx;
  logic [NUM_SRCS-1:0]               en_q;
  logic [NUM_CPUS-1:0][NUM_SRCS-1:0] msk_q;
  logic [NUM_SRCS-1:0][NUM_CPUS-1:0] route_q;
  logic [NUM_CPUS-1:0][NUM_SRCS-1:0] route_col;
  logic [IDX_W-1:0]                  ack [NUM_CPUS];

  logic [ADDR_W-1:0] rt_off;
  logic [ADDR_W-3:0] rt_word;
  logic              rt_hit;
  logic [IDX_W-1:0]  rt_idx;
  logic              unused_wdata;

  assign rt_off  = bus_addr_i - ADDR_W'(OFS_ROUTE);
  assign rt_word = rt_off[ADDR_W-1:2];
  assign rt_hit  = (bus_addr_i >= ADDR_W'(OFS_ROUTE)) && (bus_addr_i[1:0] == 2'b00);
  // out-of-range routing offsets map to the idle index, which matches no source
  assign rt_idx  = (rt_hit && (rt_word < (ADDR_W-2)'(NUM_SRCS))) ? IDX_W'(rt_word) : IDX_NONE;
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:IDX_W];

  always_comb begin
    op = OP_NONE;
    if (bus_en_i && bus_we_i) begin
      if      (bus_addr_i == ADDR_W'(OFS_EN_SET))  op = OP_EN_SET;
      else if (bus_addr_i == ADDR_W'(OFS_EN_CLR))  op = OP_EN_CLR;
      else if (bus_addr_i == ADDR_W'(OFS_MSK_SET)) op = OP_MSK_SET;
      else if (bus_addr_i == ADDR_W'(OFS_MSK_CLR)) op = OP_MSK_CLR;
      else if (rt_hit)                             op = OP_ROUTE;
    end
  end

  assign idx = (op == OP_ROUTE) ? rt_idx : bus_wdata_i[IDX_W-1:0];

  irq_bank_regs #(
    .NUM_CPUS (NUM_CPUS),
    .NUM_SRCS (NUM_SRCS),
    .CPU_W    (CPU_W)
  ) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .idx_i     (idx),
    .cpu_i     (bus_cpu_i),
    .route_d_i (bus_wdata_i[NUM_CPUS-1:0]),
    .en_o      (en_q),
    .msk_o     (msk_q),
    .route_o   (route_q)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar s = 0; s < NUM_SRCS; s++) begin : g_col
      assign route_col[c][s] = route_q[s][c];
    end

    irq_cpu_sel #(
      .NUM_SRCS  (NUM_SRCS),
      .PCPU_LAST (PCPU_LAST)
    ) i_sel (
      .src_i   (src_i),
      .en_i    (en_q),
      .msk_i   (msk_q[c]),
      .route_i (route_col[c]),
      .irq_o   (irq_o[c]),
      .ack_o   (ack[c])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_en_i && !bus_we_i) begin
      if (bus_addr_i == ADDR_W'(OFS_CTRL)) begin
        bus_rdata_o[IDX_W+1:2] = IDX_W'(NUM_SRCS);
      end else if (bus_addr_i == ADDR_W'(OFS_ACK)) begin
        bus_rdata_o[IDX_W-1:0] = IDX_NONE;
        for (int c = 0; c < NUM_CPUS; c++)
          if (bus_cpu_i == CPU_W'(c)) bus_rdata_o[IDX_W-1:0] = ack[c];
      end else if (rt_hit) begin
        for (int s = 0; s < NUM_SRCS; s++)
          if (rt_idx == IDX_W'(s)) bus_rdata_o[NUM_CPUS-1:0] = route_q[s];
      end
    end
  end
endmodule

// File: rtl/irq_mask_checker.sv
module irq_mask_checker
  import irq_mask_pkg::*;
#(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_SRCS  = 64,
  parameter int ADDR_W    = 12,
  parameter int CPU_W     = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_SRCS-1:0] src_i,
  input logic                bus_en_i,
  input logic                bus_we_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [DATA_W-1:0]   bus_wdata_i,
  input logic [CPU_W-1:0]    bus_cpu_i,
  input logic [DATA_W-1:0]   bus_rdata_o,
  input logic [NUM_CPUS-1:0] irq_o
);
  logic rd_ack, rd_rt, wr_en_bad;
  assign rd_ack = bus_en_i && !bus_we_i && (bus_addr_i == ADDR_W'(OFS_ACK));
  assign rd_rt  = bus_en_i && !bus_we_i && (bus_addr_i >= ADDR_W'(OFS_ROUTE));
  assign wr_en_bad = bus_en_i && bus_we_i &&
                     ((bus_addr_i == ADDR_W'(OFS_EN_SET)) || (bus_addr_i == ADDR_W'(OFS_EN_CLR))) &&
                     (bus_wdata_i[IDX_W-1:0] >= IDX_W'(NUM_SRCS));

  // R6: line level agrees with the acknowledge value of the reading CPU
  a_r6_line_matches_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack |-> (irq_o[bus_cpu_i] == (bus_rdata_o[IDX_W-1:0] != IDX_NONE)));

  a_r7_ack_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack |-> (bus_rdata_o[DATA_W-1:IDX_W] == '0));

  a_r4_route_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rt |-> (bus_rdata_o[DATA_W-1:NUM_CPUS] == '0));

  a_r9_bad_index_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_bad |=> ((src_i != $past(src_i)) || $stable(irq_o)));

  always @(negedge clk_i)
    if (!rst_ni) a_r1_quiet_in_reset: assert (irq_o == '0);
endmodule

bind irq_mask_ctrl irq_mask_checker #(
  .NUM_CPUS (NUM_CPUS),
  .NUM_SRCS (NUM_SRCS),
  .ADDR_W   (ADDR_W),
  .CPU_W    (CPU_W)
) i_irq_mask_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_i       (src_i),
  .bus_en_i    (bus_en_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_cpu_i   (bus_cpu_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o)
);

// File: tb/test_irq_mask_ctrl.sv
`timescale 1ns/1ps
module test_irq_mask_ctrl;
  localparam int NC = 4;
  localparam int NS = 64;
  localparam int PL = 28;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [NS-1:0] src = '0;
  logic          en = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [1:0]    cpu = '0;
  logic [31:0]   rdata;
  logic [NC-1:0] irq;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  irq_mask_ctrl #(.NUM_CPUS(NC), .NUM_SRCS(NS), .PCPU_LAST(PL), .ADDR_W(AW)) i_irq_mask_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_cpu_i(cpu),
    .bus_rdata_o(rdata), .irq_o(irq));

  // behavioural reference
  bit       m_en  [NS];
  bit       m_msk [NC][NS];
  bit [3:0] m_rt  [NS];

  always @(posedge clk or negedge rst_n) begin
    int ix, w;
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin
        m_en[s] = 0; m_rt[s] = 0;
        for (int c = 0; c < NC; c++) m_msk[c][s] = 1;
      end
    end else if (en && we) begin
      ix = int'(wdata[9:0]);
      if (ix < NS) begin
        case (addr)
          12'h030: m_en[ix] = 1;
          12'h034: m_en[ix] = 0;
          12'h048: m_msk[cpu][ix] = 1;
          12'h04C: m_msk[cpu][ix] = 0;
          default: ;
        endcase
      end
      if (addr >= 12'h100 && addr[1:0] == 2'b00) begin
        w = (int'(addr) - 'h100) / 4;
        if (w < NS) m_rt[w] = wdata[3:0];
      end
    end
  end

  function automatic bit elig(int c, int s);
    return src[s] && m_en[s] && !m_msk[c][s] && (s <= PL || m_rt[s][c]);
  endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) if (elig(c, s)) r[c] = 1'b1;
    return r;
  endfunction

  function automatic int exp_ack(int c);
    for (int s = 0; s < NS; s++) if (elig(c, s)) return s;
    return 1023;
  endfunction

  function automatic logic [31:0] exp_rdata();
    int w;
    if (!en || we) return 0;
    if (addr == 12'h000) return NS << 2;
    if (addr == 12'h044) return exp_ack(int'(cpu));
    if (addr >= 12'h100 && addr[1:0] == 2'b00) begin
      w = (int'(addr) - 'h100) / 4;
      if (w < NS) return {28'h0, m_rt[w]};
    end
    return 0;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    #1;
    check({cur_req, " irq"}, 32'(irq), 32'(exp_irq()));
    check({cur_req, " rdata"}, rdata, exp_rdata());
  end

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [1:0] c = 0);
    @(negedge clk);
    en = 1; we = 1; addr = a; wdata = d; cpu = c;
    @(negedge clk);
    en = 0; we = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [1:0] c, output logic [31:0] d);
    @(negedge clk);
    en = 1; we = 0; addr = a; cpu = c;
    #2 d = rdata;
    @(negedge clk);
    en = 0;
  endtask

  task automatic chk_irq(string req, logic [NC-1:0] exp);
    #1 check(req, 32'(irq), 32'(exp));
  endtask

  task automatic chk_rd(string req, logic [11:0] a, logic [1:0] c, logic [31:0] exp);
    logic [31:0] d;
    rd(a, c, d);
    check(req, d, exp);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk_irq("R1", 4'b0000);
    rst_n = 1;
    for (int c = 0; c < NC; c++) chk_rd("R1", 12'h044, 2'(c), 1023);
    chk_rd("R1", 12'h100 + 4 * 10, 0, 0);
    cur_req = "R8";
    chk_rd("R8", 12'h000, 1, 32'd256);

    cur_req = "R2";
    src[40] = 1;
    wr(12'h100 + 4 * 40, 32'h4);
    wr(12'h04C, 40, 2);
    chk_irq("R2", 4'b0000);
    wr(12'h030, 40);
    chk_irq("R2", 4'b0100);
    chk_rd("R2", 12'h044, 2, 40);
    wr(12'h034, 40);
    chk_irq("R2", 4'b0000);

    cur_req = "R3";
    src[5] = 1;
    wr(12'h030, 5);
    wr(12'h04C, 5, 1);
    chk_irq("R3", 4'b0010);
    chk_rd("R3", 12'h044, 0, 1023);
    wr(12'h048, 5, 1);
    chk_irq("R3", 4'b0000);

    cur_req = "R5";
    src[50] = 1;
    wr(12'h030, 50);
    wr(12'h100 + 4 * 50, 32'h1);
    for (int c = 0; c < NC; c++) wr(12'h04C, 50, 2'(c));
    chk_irq("R5", 4'b0001);
    wr(12'h04C, 5, 3);
    chk_irq("R5", 4'b1001);

    cur_req = "R7";
    src[3] = 1;
    wr(12'h030, 3);
    wr(12'h04C, 3, 3);
    chk_rd("R7", 12'h044, 3, 3);
    chk_rd("R7", 12'h044, 3, 3);
    wr(12'h048, 3, 3);
    chk_rd("R7", 12'h044, 3, 5);

    cur_req = "R6";
    src[5] = 0;
    chk_irq("R6", 4'b0001);
    chk_rd("R6", 12'h044, 3, 1023);
    src[50] = 0;
    chk_irq("R6", 4'b0000);
    src[50] = 1;
    chk_irq("R6", 4'b0001);

    cur_req = "R9";
    src[63] = 1;
    wr(12'h100 + 4 * 63, 32'h2);
    wr(12'h04C, 63, 1);
    wr(12'h030, 64);
    wr(12'h030, 1000);
    chk_irq("R9", 4'b0001);
    wr(12'h030, 32'h400 | 63);
    chk_irq("R9", 4'b0011);
    wr(12'h034, 32'hFFFF_FC00 | 64);
    chk_irq("R9", 4'b0011);
    wr(12'h200, 32'hF);
    chk_rd("R9", 12'h200, 0, 0);
    chk_rd("R9", 12'h100 + 4 * 0, 0, 0);

    cur_req = "R4";
    wr(12'h100 + 4 * 33, 32'hFFFF_FFFF);
    chk_rd("R4", 12'h100 + 4 * 33, 0, 32'hF);
    chk_rd("R4", 12'h100 + 4 * 50, 2, 32'h1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule